// File: doc/BRIEF.md
# Sized Execution Unit with Condition Codes

This block is the arithmetic and bit-manipulation stage of a 32-bit datapath. Each cycle it takes an operation code, an operand size, a source and a destination operand, and the current condition-code vector. One clock later it presents the new destination register value and the next condition-code vector.

The supported operations are add, subtract and compare, an address-style add that never touches the flags, and a 16x16 unsigned multiply. It also swaps the halves of a register and does one-position logical shifts, arithmetic shifts and rotates. Byte and word operations write only the low part of the destination and keep its upper bits. The flags always describe the sized result, never the merged 32-bit value.

The flag vector is five bits wide and ordered X (extend), N (negative), Z (zero), V (overflow), C (carry). The surrounding pipeline stores this vector and returns it on the next operation.

Top module: `ccr_exec_unit`

## Requirements
- R1: Both outputs are registers. They take the value for the inputs present at a rising clock edge at that edge and hold it until the next edge. A synchronous active-high `rst` sets `result_o` and `ccr_o` to zero.
- R2: Size codes are 2'b00 byte, 2'b01 word and 2'b10 or 2'b11 long. For add, subtract and all shifts and rotates, a byte writes bits 7:0 and a word writes bits 15:0 of the destination, and the other bits keep their `dst_i` values. Long writes all 32 bits.
- R3: The flag vector is X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Wherever N and Z are updated, N is the top bit of the sized result and Z is 1 when the sized result is all zeros.
- R4: Op 4'd0 (add) computes dst+src at the chosen size. C and X both take the carry out of the sized result. V is 1 when both operands have the same sign and the result sign differs from it.
- R5: Op 4'd1 (subtract) computes dst-src at the chosen size. C and X both take the borrow. V is 1 when the operand signs differ and the result sign differs from the destination sign.
- R6: Op 4'd2 (compare) sets N, Z, V and C exactly as subtract does. It leaves X and the whole destination value unchanged.
- R7: Op 4'd3 (address add) writes dst plus the source to all 32 bits. At word size the source is the sign-extended low 16 bits, and at long size it is the full source. The flags are unchanged. At byte size, which is illegal, the destination and the flags pass through unchanged.
- R8: Op 4'd4 (multiply) writes the 32-bit unsigned product of the low 16 bits of both operands, whatever the size. It updates N and Z from the full 32 bits, clears V and C, and keeps X.
- R9: Op 4'd5 (swap) exchanges bits 31:16 and 15:0 of the destination. It updates N and Z from the 32-bit result, clears V and C, and keeps X.
- R10: Op 4'd6 shifts the sized destination left by one and op 4'd7 shifts it right by one, filling with 0. The bit shifted out goes to C and X, and V is cleared.
- R11: Op 4'd8 (arithmetic left) behaves as op 4'd6, except that V is 1 when the sized top bit changes. Op 4'd9 (arithmetic right) keeps the sized top bit, sends bit 0 to C and X, and clears V.
- R12: Op 4'd10 rotates the sized value left and op 4'd11 rotates it right by one. The bit that wraps around is copied into C. V is cleared and X is kept.
- R13: Op codes 4'd12 to 4'd15 return the destination unchanged and keep all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand (old register value) |
| ccr_i | input | 5 | Current flags, XNZVC |
| result_o | output | 32 | New destination value, registered |
| ccr_o | output | 5 | Next flags, XNZVC, registered |

## Verification
The bench aims at cases where the sized result and the full 32-bit value disagree. One is a byte add that wraps to zero while the upper bytes are non-zero. A design that computed Z from the merged word would miss the zero there, and one that did not merge would wipe out the upper bytes. It also checks signed overflow against carry in both directions. A swapped V/C or a wrong borrow polarity shows up as wrong flag bits. Compare and rotate are driven with X preset to a value they must keep, so logic that writes the carry into X gets caught. Address add is checked at word size with a negative low half, where a missing sign extension gives a result 64K too high, and at the illegal byte size, where any write is an error.

// File: rtl/ccr_exec_pkg.sv
package ccr_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_ADDA = 4'd3,
    OP_MULU = 4'd4,
    OP_SWAP = 4'd5,
    OP_LSL  = 4'd6,
    OP_LSR  = 4'd7,
    OP_ASL  = 4'd8,
    OP_ASR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_R12  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } alu_op_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  localparam int FLG_X = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
  localparam int FLG_W = 5;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/ccr_addsub.sv
module ccr_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  always_comb begin
    if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
    else       wide = {1'b0, a_i} + {1'b0, b_i};
  end

  assign sum_o   = wide[W-1:0];
  assign carry_o = wide[W];

  // signed overflow from operand and result signs
  always_comb begin
    if (sub_i)
      ovf_o = (a_i[W-1] ^ b_i[W-1]) & (wide[W-1] ^ a_i[W-1]);
    else
      ovf_o = ~(a_i[W-1] ^ b_i[W-1]) & (wide[W-1] ^ a_i[W-1]);
  end
endmodule

// File: rtl/ccr_shift1.sv
module ccr_shift1
  import ccr_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] res_o,
  output logic         out_o,
  output logic         ovf_o
);
  always_comb begin
    res_o = val_i;
    out_o = 1'b0;
    ovf_o = 1'b0;
    unique case (op_i)
      OP_LSL: begin
        res_o = {val_i[W-2:0], 1'b0};
        out_o = val_i[W-1];
      end
      OP_ASL: begin
        res_o = {val_i[W-2:0], 1'b0};
        out_o = val_i[W-1];
        ovf_o = val_i[W-1] ^ val_i[W-2];
      end
      OP_LSR: begin
        res_o = {1'b0, val_i[W-1:1]};
        out_o = val_i[0];
      end
      OP_ASR: begin
        res_o = {val_i[W-1], val_i[W-1:1]};
        out_o = val_i[0];
      end
      OP_ROL: begin
        res_o = {val_i[W-2:0], val_i[W-1]};
        out_o = val_i[W-1];
      end
      OP_ROR: begin
        res_o = {val_i[0], val_i[W-1:1]};
        out_o = val_i[0];
      end
      default: begin
        res_o = val_i;
        out_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ccr_exec_unit.sv
module ccr_exec_unit
  import ccr_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [FLG_W-1:0]  ccr_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLG_W-1:0]  ccr_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic       is_sub;
  logic [1:0] lane_idx;
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign lane_idx = size_i[1] ? 2'd2 : (size_i[0] ? 2'd1 : 2'd0);

  logic [DATA_W-1:0] as_res   [NUM_LANES];
  logic              as_c     [NUM_LANES];
  logic              as_v     [NUM_LANES];
  logic [DATA_W-1:0] sh_res   [NUM_LANES];
  logic              sh_out   [NUM_LANES];
  logic              sh_v     [NUM_LANES];
  logic [DATA_W-1:0] lane_msk [NUM_LANES];

  // one adder and one shifter per operand size
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? BYTE_W : ((g == 1) ? HALF_W : DATA_W);
    logic [LW-1:0] sum_w;
    logic [LW-1:0] shf_w;

    ccr_addsub #(.W(LW)) u_addsub (
      .a_i    (dst_i[LW-1:0]),
      .b_i    (src_i[LW-1:0]),
      .sub_i  (is_sub),
      .sum_o  (sum_w),
      .carry_o(as_c[g]),
      .ovf_o  (as_v[g])
    );

    ccr_shift1 #(.W(LW)) u_shift (
      .op_i (op),
      .val_i(dst_i[LW-1:0]),
      .res_o(shf_w),
      .out_o(sh_out[g]),
      .ovf_o(sh_v[g])
    );

    assign as_res[g]   = DATA_W'(sum_w);
    assign sh_res[g]   = DATA_W'(shf_w);
    assign lane_msk[g] = DATA_W'({LW{1'b1}});
  end

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] adda_src;
  logic [DATA_W-1:0] product;
  assign mask     = lane_msk[lane_idx];
  assign adda_src = size_i[1] ? src_i : {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
  assign product  = DATA_W'(dst_i[HALF_W-1:0]) * DATA_W'(src_i[HALF_W-1:0]);

  function automatic logic sized_msb(input logic [DATA_W-1:0] r, input logic [1:0] idx);
    case (idx)
      2'd0:    sized_msb = r[BYTE_W-1];
      2'd1:    sized_msb = r[HALF_W-1];
      default: sized_msb = r[DATA_W-1];
    endcase
  endfunction

  logic [DATA_W-1:0] nx_res;
  logic [FLG_W-1:0]  nx_ccr;
  logic [DATA_W-1:0] lane_r;

  always_comb begin
    nx_res = dst_i;
    nx_ccr = ccr_i;
    lane_r = '0;
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        lane_r        = as_res[lane_idx];
        nx_ccr[FLG_N] = sized_msb(lane_r, lane_idx);
        nx_ccr[FLG_Z] = (lane_r & mask) == '0;
        nx_ccr[FLG_V] = as_v[lane_idx];
        nx_ccr[FLG_C] = as_c[lane_idx];
        if (op != OP_CMP) begin
          nx_ccr[FLG_X] = as_c[lane_idx];
          nx_res        = (dst_i & ~mask) | (lane_r & mask);
        end
      end
      OP_ADDA: begin
        if (size_i != SZ_BYTE) nx_res = dst_i + adda_src;
      end
      OP_MULU, OP_SWAP: begin
        nx_res        = (op == OP_MULU) ? product : {dst_i[HALF_W-1:0], dst_i[DATA_W-1:HALF_W]};
        nx_ccr[FLG_N] = nx_res[DATA_W-1];
        nx_ccr[FLG_Z] = nx_res == '0;
        nx_ccr[FLG_V] = 1'b0;
        nx_ccr[FLG_C] = 1'b0;
      end
      OP_LSL, OP_LSR, OP_ASL, OP_ASR, OP_ROL, OP_ROR: begin
        lane_r        = sh_res[lane_idx];
        nx_res        = (dst_i & ~mask) | (lane_r & mask);
        nx_ccr[FLG_N] = sized_msb(lane_r, lane_idx);
        nx_ccr[FLG_Z] = (lane_r & mask) == '0;
        nx_ccr[FLG_V] = sh_v[lane_idx];
        nx_ccr[FLG_C] = sh_out[lane_idx];
        if (op != OP_ROL && op != OP_ROR) nx_ccr[FLG_X] = sh_out[lane_idx];
      end
      default: begin
        nx_res = dst_i;
        nx_ccr = ccr_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ccr_o    <= '0;
    end else begin
      result_o <= nx_res;
      ccr_o    <= nx_ccr;
    end
  end

  logic merge_op;
  assign merge_op = (op == OP_ADD) || (op == OP_SUB) ||
                    ((op >= OP_LSL) && (op <= OP_ROR));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0) && (ccr_o == '0));

  // R2
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (merge_op && size_i == SZ_BYTE) |=>
      result_o[DATA_W-1:BYTE_W] == $past(dst_i[DATA_W-1:BYTE_W]));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> (result_o == $past(dst_i)) && (ccr_o[FLG_X] == $past(ccr_i[FLG_X])));

  // R7
  adda_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADDA) |=> ccr_o == $past(ccr_i));

  // R8
  mulu_vc_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MULU) |=> (ccr_o[FLG_V] == 1'b0) && (ccr_o[FLG_C] == 1'b0));

  // R12
  rol_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ROL && size_i[1]) |=> ccr_o[FLG_C] == result_o[0]);
endmodule

// File: tb/ccr_exec_unit_tb.sv
module ccr_exec_unit_tb;
  import ccr_exec_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [31:0] src;
    logic [31:0] dst;
    logic [4:0]  cin;
    logic [31:0] eres;
    logic [4:0]  eccr;
    logic [3:0]  req;
  } vec_t;

  // flags written XNZVC
  localparam vec_t VECS [NV] = '{
    '{OP_ADD,  2'b00, 32'h12345678, 32'h22334455, 5'b00000, 32'h223344CD, 5'b01010, 4'd4},  // R4 byte overflow
    '{OP_ADD,  2'b01, 32'h12345678, 32'h22334455, 5'b00000, 32'h22339ACD, 5'b01010, 4'd4},  // R4 word
    '{OP_ADD,  2'b10, 32'h12345678, 32'h22334455, 5'b11111, 32'h34679ACD, 5'b00000, 4'd4},  // R4 long
    '{OP_ADD,  2'b00, 32'h00000001, 32'hAABBCCFF, 5'b00000, 32'hAABBCC00, 5'b10101, 4'd3},  // R3 sized Z, R2 merge
    '{OP_SUB,  2'b01, 32'h00000003, 32'h12340005, 5'b10000, 32'h12340002, 5'b00000, 4'd5},  // R5
    '{OP_SUB,  2'b00, 32'h00000001, 32'h00000000, 5'b00000, 32'h000000FF, 5'b11001, 4'd5},  // R5 borrow
    '{OP_SUB,  2'b10, 32'h00000001, 32'h80000000, 5'b00000, 32'h7FFFFFFF, 5'b00010, 4'd5},  // R5 overflow
    '{OP_CMP,  2'b01, 32'h00000003, 32'hABCD0005, 5'b10000, 32'hABCD0005, 5'b10000, 4'd6},  // R6
    '{OP_CMP,  2'b10, 32'h00000007, 32'h00000007, 5'b00000, 32'h00000007, 5'b00100, 4'd6},  // R6 equal
    '{OP_CMP,  2'b00, 32'h00000002, 32'h00000001, 5'b00000, 32'h00000001, 5'b01001, 4'd6},  // R6 borrow, X kept 0
    '{OP_ADDA, 2'b01, 32'h2C34C11C, 32'h0112B33C, 5'b01011, 32'h01127458, 5'b01011, 4'd7},  // R7 sign extend
    '{OP_ADDA, 2'b10, 32'h2C34C11C, 32'h0112B33C, 5'b10100, 32'h2D477458, 5'b10100, 4'd7},  // R7 long
    '{OP_ADDA, 2'b00, 32'h2C34C11C, 32'h0112B33C, 5'b00001, 32'h0112B33C, 5'b00001, 4'd7},  // R7 illegal byte
    '{OP_MULU, 2'b01, 32'h1234A678, 32'hA0120002, 5'b11011, 32'h00014CF0, 5'b10000, 4'd8},  // R8
    '{OP_MULU, 2'b10, 32'h336B4105, 32'hB11CA024, 5'b00000, 32'h28AC44B4, 5'b00000, 4'd8},  // R8
    '{OP_MULU, 2'b01, 32'h1234FFFF, 32'hFFFF0000, 5'b10011, 32'h00000000, 5'b10100, 4'd8},  // R8 zero
    '{OP_SWAP, 2'b10, 32'h00000000, 32'h12345678, 5'b00011, 32'h56781234, 5'b00000, 4'd9},  // R9
    '{OP_SWAP, 2'b10, 32'h00000000, 32'h00008001, 5'b10000, 32'h80010000, 5'b11000, 4'd9},  // R9 negative
    '{OP_LSL,  2'b00, 32'h00000000, 32'h123456C1, 5'b00000, 32'h12345682, 5'b11001, 4'd10}, // R10
    '{OP_LSR,  2'b01, 32'h00000000, 32'h12348001, 5'b00000, 32'h12344000, 5'b10001, 4'd10}, // R10
    '{OP_LSR,  2'b10, 32'h00000000, 32'h00000002, 5'b10000, 32'h00000001, 5'b00000, 4'd10}, // R10 X cleared
    '{OP_ASL,  2'b01, 32'h00000000, 32'h00004000, 5'b10000, 32'h00008000, 5'b01010, 4'd11}, // R11 sign change
    '{OP_ASR,  2'b00, 32'h00000000, 32'h00000081, 5'b00000, 32'h000000C0, 5'b11001, 4'd11}, // R11
    '{OP_ASR,  2'b10, 32'h00000000, 32'h80000000, 5'b00000, 32'hC0000000, 5'b01000, 4'd11}, // R11
    '{OP_ROL,  2'b00, 32'h00000000, 32'hFFFFFF81, 5'b00000, 32'hFFFFFF03, 5'b00001, 4'd12}, // R12
    '{OP_ROR,  2'b10, 32'h00000000, 32'h00000001, 5'b10010, 32'h80000000, 5'b11001, 4'd12}, // R12 X kept
    '{OP_R15,  2'b10, 32'hFFFFFFFF, 32'h12345678, 5'b10101, 32'h12345678, 5'b10101, 4'd13}, // R13
    '{OP_ADD,  2'b11, 32'h00000001, 32'h00000001, 5'b00000, 32'h00000002, 5'b00000, 4'd2}   // R2 size 11 is long
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] dst_i = '0;
  logic [4:0]  ccr_i = '0;
  logic [31:0] result_o;
  logic [4:0]  ccr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_exec_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i),
    .src_i(src_i), .dst_i(dst_i), .ccr_i(ccr_i),
    .result_o(result_o), .ccr_o(ccr_o)
  );

  task automatic check(input string tag, input logic [31:0] er, input logic [4:0] ec);
    n_tests++;
    if (result_o !== er || ccr_o !== ec) begin
      n_fail++;
      $display("FAIL %s: result %h ccr %b, expected result %h ccr %b", tag, result_o, ccr_o, er, ec);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [1:0] s, input logic [31:0] sr,
                       input logic [31:0] d, input logic [4:0] c);
    @(negedge clk);
    op_i = o; size_i = s; src_i = sr; dst_i = d; ccr_i = c;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", 32'h0, 5'b00000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].sz, VECS[i].src, VECS[i].dst, VECS[i].cin);
      @(posedge clk);
      #1;
      n_tests++;
      if (result_o !== VECS[i].eres || ccr_o !== VECS[i].eccr) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: result %h ccr %b, expected result %h ccr %b",
                 VECS[i].req, i, result_o, ccr_o, VECS[i].eres, VECS[i].eccr);
      end
    end

    // R1: output holds between edges
    drive(OP_ADD, 2'b10, 32'h1, 32'h10, 5'b00000);
    @(posedge clk); #1;
    check("R1 latency", 32'h11, 5'b00000);
    drive(OP_SUB, 2'b10, 32'h1, 32'h10, 5'b00000);
    #1;
    check("R1 hold before edge", 32'h11, 5'b00000);
    @(posedge clk); #1;
    check("R1 after edge", 32'h0F, 5'b00000);

    // R1: mid-run reset
    drive(OP_ADD, 2'b10, 32'h5, 32'h5, 5'b11111);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 sync reset", 32'h0, 5'b00000);
    @(negedge clk);
    rst = 1'b0;

    // R13: another unused code with word size
    drive(OP_R12, 2'b01, 32'h0000FFFF, 32'hCAFE0001, 5'b01110);
    @(posedge clk); #1;
    check("R13 unused op", 32'hCAFE0001, 5'b01110);

    // R12: word rotate left keeps upper half and X
    drive(OP_ROL, 2'b01, 32'h0, 32'h55558000, 5'b00000);
    @(posedge clk); #1;
    check("R12 word rol", 32'h55550001, 5'b00001);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule